// File: doc/BRIEF.md
# UART Interrupt Prioritizer and Identifier

This block gathers the interrupt conditions of one UART channel and presents the most urgent one as an 8-bit identification byte that the host reads, together with an interrupt request line. Seven sources are ranked in a fixed order. Line-status errors come first, then received data at the trigger level, receive timeout, transmitter empty, modem status change, a flow-control or special character match, and finally a rising edge on the CTS or RTS line. The byte's low bit is active low, and its top two bits mirror the FIFO enable.

Each source has its own way of going away. Line and modem status stay pending until their own clear inputs fire. Transmitter empty is cleared by a host data write, or by a status read while it is the reported source. A flow-control character match is cleared by a status read. A special-character match is cleared by a status read or by the next received character. The two extended sources are active only while the enhanced-feature enable is set. The receive-data source compares the FIFO fill count against one of four trigger levels. A single shared trigger selection register holds that choice, and the most recent write sets it.

Top module: `uart_irq_id`

## Requirements
- R1: While reset is applied, `status` reads 0x01 and `irq` is 0.
- R2: `status[7:6]` is 2'b11 when `fifo_en` is 1 and 2'b00 when it is 0.
- R3: `status[5:0]` reports the highest pending source, listed here from highest to lowest priority: line status 000110, receive data 000100, receive timeout 001100, transmitter empty 000010, modem status 000000, character match 010000, flow edge 100000. With nothing pending it reads 000001.
- R4: Receive data is pending when `rx_count` is at least the trigger level. With `fifo_en` high, `trig_sel` codes 0, 1, 2 and 3 select levels 1, 4, 8 and 14. The code is latched by `trig_wr`, and the last write wins. It resets to code 0. With `fifo_en` low the level is 1.
- R5: Line status and modem status become pending on their event inputs and clear only on their own clear inputs. A status read leaves them pending. An event wins over a clear that arrives in the same cycle.
- R6: Transmitter empty clears on `tx_wr`, or on a read while 000010 is the reported value. A read while another value is reported leaves it pending.
- R7: A flow-control character match (`xon_hit`) clears on a read while 010000 is reported.
- R8: A special character match (`spc_hit`) clears on a read while 010000 is reported, or on the next `rx_char`. An `rx_char` in the same cycle as the match does not clear it.
- R9: A low-to-high transition of `cts_lvl` or `rts_lvl` makes the flow edge source pending. It clears on a read while 100000 is reported.
- R10: While `ext_en` is 0, the character match and flow edge sources are held clear and are never reported.
- R11: Inputs sampled at a clock edge show in `status` and `irq` right after that edge. During any cycle with `isr_rd` high, both outputs hold their previous values. Read-clears act on the value that is being held.
- R12: `irq` is registered and always equals the inverse of `status[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFO mode enable |
| ext_en | input | 1 | Enhanced-feature enable for the two extended sources |
| trig_wr | input | 1 | Write strobe for the trigger selection |
| trig_sel | input | 2 | Trigger level code |
| rx_count | input | 6 | Receive FIFO fill count |
| rx_tmo | input | 1 | Receive timeout condition (level) |
| line_evt | input | 1 | Line status error event |
| line_clr | input | 1 | Line status source clear |
| modem_evt | input | 1 | Modem status change event |
| modem_clr | input | 1 | Modem status source clear |
| txe_evt | input | 1 | Transmit holding register became empty |
| tx_wr | input | 1 | Host wrote transmit data |
| xon_hit | input | 1 | Flow-control character matched |
| spc_hit | input | 1 | Special character matched |
| rx_char | input | 1 | A character was received |
| cts_lvl | input | 1 | CTS line level |
| rts_lvl | input | 1 | RTS line level |
| isr_rd | input | 1 | Status register read strobe |
| status | output | 8 | Interrupt identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The checker properties assume single-cycle event pulses, and a read strobe whose effect is judged only when no other event lands at the same edge. The event-based properties carry `!isr_rd` as a precondition, so they never check a value that is being held. The stimulus drives every input at the falling edge, keeps each event high for exactly one cycle, and keeps `cts_lvl` and `rts_lvl` low through reset, so no false edge appears. A behavioural model in the bench, built from flags and if-chains, predicts both outputs on every clock.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC = 7;

  typedef enum logic [5:0] {
    ID_LINE    = 6'b000110,
    ID_RXDATA  = 6'b000100,
    ID_RXTMO   = 6'b001100,
    ID_TXEMPTY = 6'b000010,
    ID_MODEM   = 6'b000000,
    ID_CHAR    = 6'b010000,
    ID_FLOW    = 6'b100000,
    ID_NONE    = 6'b000001
  } irq_id_e;

  // index 0 is the highest priority
  function automatic irq_id_e code_of(input int idx);
    case (idx)
      0:       return ID_LINE;
      1:       return ID_RXDATA;
      2:       return ID_RXTMO;
      3:       return ID_TXEMPTY;
      4:       return ID_MODEM;
      5:       return ID_CHAR;
      default: return ID_FLOW;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_rxtrig.sv
module uart_irq_rxtrig #(
  parameter int DEPTH = 32,
  parameter int LVL0  = 1,
  parameter int LVL1  = 4,
  parameter int LVL2  = 8,
  parameter int LVL3  = 14,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          trig_wr,
  input  logic [1:0]    trig_sel,
  input  logic [CW-1:0] rx_count,
  output logic          rx_hit
);
  localparam int LVLS [4] = '{LVL0, LVL1, LVL2, LVL3};

  logic [CW-1:0] lvl_tab [4];
  logic [1:0]    sel_q;
  logic [1:0]    sel_d;
  logic [CW-1:0] lvl_now;

  for (genvar i = 0; i < 4; i++) begin : g_lvl
    assign lvl_tab[i] = CW'(LVLS[i]);
  end

  always_comb begin
    sel_d   = trig_wr ? trig_sel : sel_q;
    lvl_now = fifo_en ? lvl_tab[sel_d] : CW'(1);
    rx_hit  = (rx_count >= lvl_now);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sel_q <= 2'b00;
    else if (trig_wr) sel_q <= trig_sel;
  end
endmodule

// File: rtl/uart_irq_sources.sv
module uart_irq_sources
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_en,
  input  logic       rd,
  input  logic [5:0] rd_id,
  input  logic       line_evt,
  input  logic       line_clr,
  input  logic       modem_evt,
  input  logic       modem_clr,
  input  logic       txe_evt,
  input  logic       tx_wr,
  input  logic       xon_hit,
  input  logic       spc_hit,
  input  logic       rx_char,
  input  logic       cts_lvl,
  input  logic       rts_lvl,
  output logic       line_d,
  output logic       modem_d,
  output logic       txe_d,
  output logic       chr_d,
  output logic       flow_d
);
  logic line_q, modem_q, txe_q, xon_q, spc_q, flow_q, cts_q, rts_q;
  logic xon_d, spc_d, rise;
  logic rd_txe, rd_chr, rd_flow;

  always_comb begin
    rd_txe  = rd && (rd_id == ID_TXEMPTY);
    rd_chr  = rd && (rd_id == ID_CHAR);
    rd_flow = rd && (rd_id == ID_FLOW);
    rise    = (cts_lvl && !cts_q) || (rts_lvl && !rts_q);

    line_d  = line_evt  | (line_q  & ~line_clr);
    modem_d = modem_evt | (modem_q & ~modem_clr);
    txe_d   = txe_evt   | (txe_q   & ~tx_wr & ~rd_txe);
    xon_d   = ext_en & (xon_hit  | (xon_q  & ~rd_chr));
    spc_d   = ext_en & (spc_hit  | (spc_q  & ~rd_chr & ~rx_char));
    flow_d  = ext_en & (rise     | (flow_q & ~rd_flow));
    chr_d   = xon_d | spc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= 1'b0;
      modem_q <= 1'b0;
      txe_q   <= 1'b0;
      xon_q   <= 1'b0;
      spc_q   <= 1'b0;
      flow_q  <= 1'b0;
      cts_q   <= 1'b0;
      rts_q   <= 1'b0;
    end else begin
      line_q  <= line_d;
      modem_q <= modem_d;
      txe_q   <= txe_d;
      xon_q   <= xon_d;
      spc_q   <= spc_d;
      flow_q  <= flow_d;
      cts_q   <= cts_lvl;
      rts_q   <= rts_lvl;
    end
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0] req,
  output logic [5:0]      id,
  output logic            pending
);
  always_comb begin
    id = ID_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) id = code_of(i);
    end
    pending = |req;
  end
endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
  import uart_irq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          ext_en,
  input  logic          trig_wr,
  input  logic [1:0]    trig_sel,
  input  logic [CW-1:0] rx_count,
  input  logic          rx_tmo,
  input  logic          line_evt,
  input  logic          line_clr,
  input  logic          modem_evt,
  input  logic          modem_clr,
  input  logic          txe_evt,
  input  logic          tx_wr,
  input  logic          xon_hit,
  input  logic          spc_hit,
  input  logic          rx_char,
  input  logic          cts_lvl,
  input  logic          rts_lvl,
  input  logic          isr_rd,
  output logic [7:0]    status,
  output logic          irq
);
  logic [1:0]      rst_pipe;
  logic            rst_sync_n;
  logic            rx_hit, line_d, modem_d, txe_d, chr_d, flow_d;
  logic [NSRC-1:0] req;
  logic [5:0]      id;
  logic            pending;
  logic [7:0]      status_d;
  logic            upd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  uart_irq_rxtrig #(.DEPTH(DEPTH)) u_trig (
    .clk(clk), .rst_n(rst_sync_n), .fifo_en(fifo_en), .trig_wr(trig_wr),
    .trig_sel(trig_sel), .rx_count(rx_count), .rx_hit(rx_hit)
  );

  uart_irq_sources u_src (
    .clk(clk), .rst_n(rst_sync_n), .ext_en(ext_en), .rd(isr_rd),
    .rd_id(status[5:0]), .line_evt(line_evt), .line_clr(line_clr),
    .modem_evt(modem_evt), .modem_clr(modem_clr), .txe_evt(txe_evt),
    .tx_wr(tx_wr), .xon_hit(xon_hit), .spc_hit(spc_hit), .rx_char(rx_char),
    .cts_lvl(cts_lvl), .rts_lvl(rts_lvl), .line_d(line_d), .modem_d(modem_d),
    .txe_d(txe_d), .chr_d(chr_d), .flow_d(flow_d)
  );

  assign req = {flow_d, chr_d, modem_d, txe_d, rx_tmo, rx_hit, line_d};

  uart_irq_prio u_prio (.req(req), .id(id), .pending(pending));

  always_comb begin
    status_d = {fifo_en, fifo_en, id};
    upd_en   = !isr_rd;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      status <= 8'h01;
      irq    <= 1'b0;
    end else if (upd_en) begin
      status <= status_d;
      irq    <= pending;
    end
  end
endmodule

// File: rtl/uart_irq_id_chk.sv
module uart_irq_id_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fifo_en,
  input logic       ext_en,
  input logic       isr_rd,
  input logic       line_evt,
  input logic       txe_evt,
  input logic       tx_wr,
  input logic [7:0] status,
  input logic       irq
);
  a_r12_irq_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    irq == !status[0]);

  a_r11_hold_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    isr_rd |=> $stable(status) && $stable(irq));

  a_r2_fifo_bits: assert property (@(posedge clk) disable iff (!rst_n)
    !isr_rd |=> status[7:6] == {$past(fifo_en), $past(fifo_en)});

  a_r3_line_first: assert property (@(posedge clk) disable iff (!rst_n)
    line_evt && !isr_rd |=> status[5:0] == 6'b000110);

  a_r10_ext_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_en && !isr_rd |=> status[5:0] != 6'b010000 && status[5:0] != 6'b100000);

  a_r6_txe_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr && !txe_evt && !isr_rd |=> status[5:0] != 6'b000010);
endmodule

bind uart_irq_id uart_irq_id_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .fifo_en(fifo_en), .ext_en(ext_en),
  .isr_rd(isr_rd), .line_evt(line_evt), .txe_evt(txe_evt), .tx_wr(tx_wr),
  .status(status), .irq(irq)
);

// File: tb/sim_uart_irq_id.sv
module sim_uart_irq_id;
  logic clk = 1'b0;
  logic rst_n;
  logic fifo_en, ext_en, trig_wr, rx_tmo, line_evt, line_clr, modem_evt, modem_clr;
  logic txe_evt, tx_wr, xon_hit, spc_hit, rx_char, cts_lvl, rts_lvl, isr_rd;
  logic [1:0] trig_sel;
  logic [5:0] rx_count;
  logic [7:0] status;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tag = "R1";

  // reference model state
  int m_line, m_modem, m_txe, m_xon, m_spc, m_flow, m_cts, m_rts, m_sel;
  logic [7:0] exp_status;
  logic       exp_irq;

  always #4 clk = ~clk;

  uart_irq_id u0 (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .ext_en(ext_en), .trig_wr(trig_wr),
    .trig_sel(trig_sel), .rx_count(rx_count), .rx_tmo(rx_tmo), .line_evt(line_evt),
    .line_clr(line_clr), .modem_evt(modem_evt), .modem_clr(modem_clr), .txe_evt(txe_evt),
    .tx_wr(tx_wr), .xon_hit(xon_hit), .spc_hit(spc_hit), .rx_char(rx_char),
    .cts_lvl(cts_lvl), .rts_lvl(rts_lvl), .isr_rd(isr_rd), .status(status), .irq(irq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string t, input logic [7:0] act_s, input logic [7:0] exp_s,
                       input logic act_i, input logic exp_i);
    checks++;
    if (act_s !== exp_s || act_i !== exp_i) begin
      errors++;
      $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b", t, act_s, act_i, exp_s, exp_i);
    end
  endtask

  task automatic model_edge();
    int rd, id, lvl, rise, code;
    rd = isr_rd;
    id = int'(exp_status[5:0]);
    if (trig_wr) m_sel = int'(trig_sel);
    if (line_evt) m_line = 1; else if (line_clr) m_line = 0;
    if (modem_evt) m_modem = 1; else if (modem_clr) m_modem = 0;
    if (txe_evt) m_txe = 1; else if (tx_wr || (rd && id == 2)) m_txe = 0;
    rise = (cts_lvl && m_cts == 0) || (rts_lvl && m_rts == 0);
    m_cts = int'(cts_lvl);
    m_rts = int'(rts_lvl);
    if (!ext_en) begin
      m_xon = 0; m_spc = 0; m_flow = 0;
    end else begin
      if (xon_hit) m_xon = 1; else if (rd && id == 16) m_xon = 0;
      if (spc_hit) m_spc = 1; else if (rx_char || (rd && id == 16)) m_spc = 0;
      if (rise) m_flow = 1; else if (rd && id == 32) m_flow = 0;
    end
    if (!fifo_en) lvl = 1;
    else if (m_sel == 0) lvl = 1;
    else if (m_sel == 1) lvl = 4;
    else if (m_sel == 2) lvl = 8;
    else lvl = 14;
    if (m_line != 0) code = 6;
    else if (int'(rx_count) >= lvl) code = 4;
    else if (rx_tmo) code = 12;
    else if (m_txe != 0) code = 2;
    else if (m_modem != 0) code = 0;
    else if (m_xon != 0 || m_spc != 0) code = 16;
    else if (m_flow != 0) code = 32;
    else code = 1;
    if (!rd) begin
      exp_status = {fifo_en, fifo_en, 6'(code)};
      exp_irq    = (code != 1);
    end
  endtask

  task automatic step();
    model_edge();
    @(posedge clk);
    @(negedge clk);
    check(tag, status, exp_status, irq, exp_irq);
    trig_wr = 0; line_evt = 0; line_clr = 0; modem_evt = 0; modem_clr = 0;
    txe_evt = 0; tx_wr = 0; xon_hit = 0; spc_hit = 0; rx_char = 0; isr_rd = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    rst_n = 0; fifo_en = 0; ext_en = 0; trig_wr = 0; trig_sel = 0; rx_count = 0;
    rx_tmo = 0; line_evt = 0; line_clr = 0; modem_evt = 0; modem_clr = 0; txe_evt = 0;
    tx_wr = 0; xon_hit = 0; spc_hit = 0; rx_char = 0; cts_lvl = 0; rts_lvl = 0; isr_rd = 0;
    m_line = 0; m_modem = 0; m_txe = 0; m_xon = 0; m_spc = 0; m_flow = 0;
    m_cts = 0; m_rts = 0; m_sel = 0; exp_status = 8'h01; exp_irq = 0;
    repeat (3) @(negedge clk);
    tag = "R1"; check(tag, status, 8'h01, irq, 1'b0);
    rst_n = 1;
    idle(3);

    // R2: FIFO enable bits
    tag = "R2"; fifo_en = 1; idle(2); fifo_en = 0; idle(1); fifo_en = 1; idle(1);

    // R3: all sources at once, peel off in priority order
    tag = "R3"; ext_en = 1;
    line_evt = 1; modem_evt = 1; txe_evt = 1; rx_count = 5; rx_tmo = 1; xon_hit = 1;
    cts_lvl = 1; step();
    line_clr = 1; step();
    rx_count = 0; step();
    rx_tmo = 0; step();
    isr_rd = 1; step(); idle(1);
    modem_clr = 1; step();
    isr_rd = 1; step(); idle(1);
    isr_rd = 1; step(); idle(1);
    cts_lvl = 0; idle(1);

    // R4: trigger levels
    tag = "R4"; trig_sel = 1; trig_wr = 1; step();
    rx_count = 3; step(); rx_count = 4; step();
    trig_sel = 2; trig_wr = 1; step(); trig_sel = 3; trig_wr = 1; step();
    rx_count = 13; step(); rx_count = 14; step(); rx_count = 8; step();
    fifo_en = 0; rx_count = 1; step(); rx_count = 0; step(); fifo_en = 1; step();

    // R5: sticky line and modem status
    tag = "R5"; line_evt = 1; step(); isr_rd = 1; step(); idle(2);
    line_clr = 1; line_evt = 1; step(); line_clr = 1; step();
    modem_evt = 1; step(); isr_rd = 1; step(); idle(1); modem_clr = 1; step();

    // R6: transmitter empty clearing
    tag = "R6"; txe_evt = 1; step(); tx_wr = 1; step();
    txe_evt = 1; line_evt = 1; step(); isr_rd = 1; step();
    line_clr = 1; step(); isr_rd = 1; step(); idle(1);

    // R7 / R8: character matches
    tag = "R7"; xon_hit = 1; step(); rx_char = 1; step(); isr_rd = 1; step(); idle(1);
    tag = "R8"; spc_hit = 1; rx_char = 1; step(); rx_char = 1; step();
    spc_hit = 1; step(); isr_rd = 1; step(); idle(1);

    // R9: flow edges
    tag = "R9"; rts_lvl = 1; step(); idle(1); isr_rd = 1; step(); idle(1);
    rts_lvl = 0; step(); cts_lvl = 1; rts_lvl = 1; step(); isr_rd = 1; step(); idle(1);
    cts_lvl = 0; rts_lvl = 0; step();

    // R10: extended sources gated
    tag = "R10"; xon_hit = 1; step(); ext_en = 0; step();
    xon_hit = 1; spc_hit = 1; cts_lvl = 1; step(); idle(2); cts_lvl = 0; idle(1);
    ext_en = 1; idle(1);

    // R11: hold during read while an event lands
    tag = "R11"; isr_rd = 1; line_evt = 1; step(); idle(1);
    isr_rd = 1; line_clr = 1; step(); idle(1);

    // R12: request follows status across states
    tag = "R12"; modem_evt = 1; step(); modem_clr = 1; step(); rx_tmo = 1; step();
    rx_tmo = 0; step();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule